// File: doc/BRIEF.md
# Disk Controller Host Command and Status Register

This block sits between a host I/O bus and the transfer engine of a head-per-track disk controller. Each host command carries a three-bit pulse field and a two-bit subcode. Together they select up to three actions: a flag operation (clear the flags, test for a skip, or clear everything), a read (the disk address or the status) or a memory-address load, and a load of the disk address, the word count or the status word. The block holds an 18-bit function/status word. It recomputes the error summary and the busy/done interlock on every update, and it drives a level interrupt request.

Loading the status does not overwrite the interrupt-enable, busy and write bits. The host word is XORed into whatever of those three bits is retained. Loading the status also sends the transfer engine a one-cycle start pulse when busy ends up set, and a one-cycle cancel pulse otherwise. The engine reports back through a flag-set vector that is ORed into the status. The memory address, disk address and word count are held here for the engine. Address conversion and data movement are done elsewhere.

Top module: `disk_csr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status, disk address, word count and memory address all clear to zero, `rd_data`, `skip` and `eng_start` are 0, and `eng_cancel` is 1.
- R2: The status bits, in octal, are: error 400000, parity 200000, illegal address 100000, timing 040000, not ready 020000, done 010000, interrupt enable 004000, busy 002000, write 001000. Bits 8..0 always read as zero.
- R3: Load-status (pulse bit 2, subcode 2) sets the status to (old AND 007000) XOR (load word AND NOT 000777), and the result is then normalised as in R4/R5.
- R4: After every update, the error bit equals the OR of the parity, illegal-address, timing and not-ready bits.
- R5: After every update, busy is clear whenever done is set.
- R6: `irq` is high exactly when (error OR done) AND interrupt enable holds in the current status.
- R7: Clear-flags (pulse bit 0, subcode 0) clears the error bit, the four error flags and done, and keeps the other bits.
- R8: Skip-test (pulse bit 0, subcode 1) sets `skip` to 1 in the cycle after the command when error or done was set before the command; otherwise `skip` is 0.
- R9: Clear-all (pulse bit 0, subcode 2) sets the whole status to zero.
- R10: Read-address (pulse bit 1, subcode 0) returns the disk address on `rd_data`, and read-status (pulse bit 1, subcode 1) returns the status as it stands after the flag operation. Both appear in the cycle after the command. `rd_data` is 0 in any cycle that follows a command without a read.
- R11: Load-MA (pulse bit 1, subcode 2) loads the low MA_W bits of the load word. Load-DA (pulse bit 2, subcode 0) loads the full 18-bit load word. Load-WC (pulse bit 2, subcode 1) loads the low WC_W bits of the load word. All other commands leave these registers unchanged.
- R12: Load-status raises `eng_start` for one cycle if busy is set in the XOR result, and raises `eng_cancel` for one cycle otherwise. `eng_write` follows the write bit.
- R13: Within one command, the pulse bits take effect in the order bit 0, bit 1, bit 2. The load word is `host_data` OR the value read by the same command.
- R14: The `eng_flags` bits {parity, illegal address, timing, not ready, done} (bit 4 down to bit 0) are ORed into the status after the host command of the same cycle, and the result is then normalised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A host command is present this cycle |
| cmd_pulse | input | 3 | Pulse bits; bit 0 = flag op, bit 1 = read/load MA, bit 2 = load |
| cmd_sub | input | 2 | Subcode 0, 1 or 2; 3 selects nothing |
| host_data | input | 18 | Host data word for loads |
| eng_flags | input | 5 | Engine flag-set: {parity, illegal addr, timing, not ready, done} |
| rd_data | output | 18 | Value read by the previous command |
| skip | output | 1 | Skip condition from the previous command |
| irq | output | 1 | Interrupt request level |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_cancel | output | 1 | One-cycle cancel pulse to the engine |
| eng_write | output | 1 | Transfer direction, 1 = write |
| mem_addr | output | MA_W | Memory address register |
| disk_addr | output | 18 | Disk address register |
| word_count | output | WC_W | Word count register |

## Verification
Every result of a command becomes visible after the single clock edge that accepts it. This covers the status, `irq`, `eng_write`, the address and count registers, and the registered `rd_data`, `skip`, `eng_start` and `eng_cancel`. The bench drives each command on a falling edge and compares every output on the next falling edge. At that point the model has advanced exactly one step. The status word has no port of its own, so it is checked through read-status commands, which show the value in the cycle after they are issued.

// File: rtl/disk_csr_pkg.sv
// Package: shared bit positions, masks, command strobe type and the
// status normalisation rule for the disk command/status register.
package disk_csr_pkg;
    localparam int STAT_W = 18;
    localparam int EFLAG_W = 5;

    localparam int B_ERR = 17;
    localparam int B_PAR = 16;
    localparam int B_ILA = 15;
    localparam int B_TIM = 14;
    localparam int B_NRY = 13;
    localparam int B_DON = 12;
    localparam int B_IE  = 11;
    localparam int B_BSY = 10;
    localparam int B_WR  = 9;
    localparam int FLAG_LSB = B_DON;

    localparam logic [STAT_W-1:0] M_EFLG = 18'o360000;
    localparam logic [STAT_W-1:0] M_KEEP = 18'o007000;
    localparam logic [STAT_W-1:0] M_LOW  = 18'o000777;
    localparam logic [STAT_W-1:0] M_ERR  = 18'o400000;
    localparam logic [STAT_W-1:0] M_DON  = 18'o010000;
    localparam logic [STAT_W-1:0] M_BSY  = 18'o002000;

    typedef enum logic [1:0] {
        SUB_0    = 2'd0,
        SUB_1    = 2'd1,
        SUB_2    = 2'd2,
        SUB_NONE = 2'd3
    } sub_e;

    typedef struct packed {
        logic clr_flags;
        logic skip_test;
        logic clr_all;
        logic rd_addr;
        logic rd_stat;
        logic ld_ma;
        logic ld_da;
        logic ld_wc;
        logic ld_stat;
    } cmd_s;

    // Apply error summary, zero low bits and done-clears-busy.
    function automatic logic [STAT_W-1:0] norm_status(input logic [STAT_W-1:0] v);
        logic [STAT_W-1:0] r;
        r = v & ~(M_ERR | M_LOW);
        if ((r & M_EFLG) != '0) r = r | M_ERR;
        if (r[B_DON]) r = r & ~M_BSY;
        return r;
    endfunction
endpackage

// File: rtl/csr_cmd_decode.sv
// Command decoder: turns the pulse bits and subcode of one host command
// into one strobe per action. Assumes at most one subcode per command;
// subcode 3 selects no action.
module csr_cmd_decode
    import disk_csr_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_pulse,
    input  logic [1:0] cmd_sub,
    output cmd_s       cmd
);
    logic [2:0][2:0] hit;   // [pulse bit][subcode]

    // One strobe for every pulse bit / subcode pair.
    for (genvar p = 0; p < 3; p++) begin : g_pulse
        for (genvar s = 0; s < 3; s++) begin : g_sub
            assign hit[p][s] = cmd_valid && cmd_pulse[p] && (cmd_sub == 2'(s));
        end
    end

    // Name the strobes.
    always_comb begin
        cmd.clr_flags = hit[0][SUB_0];
        cmd.skip_test = hit[0][SUB_1];
        cmd.clr_all   = hit[0][SUB_2];
        cmd.rd_addr   = hit[1][SUB_0];
        cmd.rd_stat   = hit[1][SUB_1];
        cmd.ld_ma     = hit[1][SUB_2];
        cmd.ld_da     = hit[2][SUB_0];
        cmd.ld_wc     = hit[2][SUB_1];
        cmd.ld_stat   = hit[2][SUB_2];
    end
endmodule

// File: rtl/csr_load_reg.sv
// Plain loadable register for the address and count words. It holds its
// value unless the load strobe is high, and clears on reset.
module csr_load_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q))
        else $error("register changed without load");
endmodule

// File: rtl/csr_status_reg.sv
// Function/status word. In one cycle it applies the flag operation, then
// the XOR load, then the engine flag-set, and then normalises the result.
// It also produces the skip condition and the start/cancel pulses.
// Assumes the strobes come from csr_cmd_decode.
module csr_status_reg
    import disk_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_s               cmd,
    input  logic [STAT_W-1:0]  ld_word,
    input  logic [EFLAG_W-1:0] eng_flags,
    output logic [STAT_W-1:0]  status_q,
    output logic [STAT_W-1:0]  status_mid,
    output logic               skip_hit,
    output logic               start_q,
    output logic               cancel_q
);
    logic [STAT_W-1:0] after_load;
    logic [STAT_W-1:0] next_status;
    logic [STAT_W-1:0] flag_set;

    // Flag operation first, then the XOR load, then the engine flags.
    always_comb begin
        if (cmd.clr_all)        status_mid = '0;
        else if (cmd.clr_flags) status_mid = status_q & ~(M_ERR | M_EFLG | M_DON);
        else                    status_mid = status_q;
        skip_hit = cmd.skip_test && (status_q[B_ERR] || status_q[B_DON]);
        if (cmd.ld_stat) after_load = (status_mid & M_KEEP) ^ (ld_word & ~M_LOW);
        else             after_load = status_mid;
        flag_set    = {{(STAT_W-FLAG_LSB-EFLAG_W){1'b0}}, eng_flags, {FLAG_LSB{1'b0}}};
        next_status = norm_status(after_load | flag_set);
    end

    // Status word and engine pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            start_q  <= 1'b0;
            cancel_q <= 1'b1;
        end else begin
            status_q <= next_status;
            start_q  <= cmd.ld_stat && after_load[B_BSY];
            cancel_q <= cmd.ld_stat && !after_load[B_BSY];
        end
    end

    p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[8:0] == '0)
        else $error("low status bits not zero");
    p_done_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_q[B_DON] && status_q[B_BSY]))
        else $error("busy with done");
    p_err_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[B_ERR] == (status_q[B_PAR] | status_q[B_ILA] | status_q[B_TIM] | status_q[B_NRY]))
        else $error("error summary mismatch");
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.clr_all && !cmd.ld_stat && eng_flags == '0) |=> (status_q == '0))
        else $error("clear-all left bits set");
    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_q, cancel_q}))
        else $error("start and cancel together");
    p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (status_q[B_BSY] || status_q[B_DON]))
        else $error("start without busy");
endmodule

// File: rtl/disk_csr.sv
// Top of the disk host command/status register. It decodes the command,
// forms the read value and the load word (host data OR read value),
// keeps the status and address registers, and registers the read result
// and skip for the cycle after the command.
module disk_csr
    import disk_csr_pkg::*;
#(
    parameter int MA_W = 15,
    parameter int WC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_pulse,
    input  logic [1:0]         cmd_sub,
    input  logic [STAT_W-1:0]  host_data,
    input  logic [EFLAG_W-1:0] eng_flags,
    output logic [STAT_W-1:0]  rd_data,
    output logic               skip,
    output logic               irq,
    output logic               eng_start,
    output logic               eng_cancel,
    output logic               eng_write,
    output logic [MA_W-1:0]    mem_addr,
    output logic [STAT_W-1:0]  disk_addr,
    output logic [WC_W-1:0]    word_count
);
    cmd_s              cmd;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] status_mid;
    logic [STAT_W-1:0] rd_val;
    logic [STAT_W-1:0] ld_word;
    logic              skip_hit;

    csr_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_pulse (cmd_pulse),
        .cmd_sub   (cmd_sub),
        .cmd       (cmd)
    );

    // Read value of this command; loads see host data OR that value.
    always_comb begin
        rd_val  = (cmd.rd_addr ? disk_addr : '0) | (cmd.rd_stat ? status_mid : '0);
        ld_word = host_data | rd_val;
    end

    csr_status_reg u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .ld_word    (ld_word),
        .eng_flags  (eng_flags),
        .status_q   (status_q),
        .status_mid (status_mid),
        .skip_hit   (skip_hit),
        .start_q    (eng_start),
        .cancel_q   (eng_cancel)
    );

    csr_load_reg #(.W(MA_W)) u_ma (
        .clk (clk), .rst_n (rst_n), .load (cmd.ld_ma),
        .d (ld_word[MA_W-1:0]), .q (mem_addr)
    );
    csr_load_reg #(.W(STAT_W)) u_da (
        .clk (clk), .rst_n (rst_n), .load (cmd.ld_da),
        .d (ld_word), .q (disk_addr)
    );
    csr_load_reg #(.W(WC_W)) u_wc (
        .clk (clk), .rst_n (rst_n), .load (cmd.ld_wc),
        .d (ld_word[WC_W-1:0]), .q (word_count)
    );

    // Registered read result and skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            skip    <= 1'b0;
        end else begin
            rd_data <= rd_val;
            skip    <= skip_hit;
        end
    end

    assign irq       = (status_q[B_ERR] | status_q[B_DON]) & status_q[B_IE];
    assign eng_write = status_q[B_WR];

    p_skip_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.skip_test && !status_q[B_ERR] && !status_q[B_DON]) |=> !skip)
        else $error("skip without cause");
    p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.clr_flags && eng_flags == '0 && !cmd.ld_stat) |=> !irq)
        else $error("irq after clear flags");
endmodule

// File: tb/tb_disk_csr.sv
module tb_disk_csr;
    localparam int MA_W = 15;
    localparam int WC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic [2:0]        cmd_pulse;
    logic [1:0]        cmd_sub;
    logic [17:0]       host_data;
    logic [4:0]        eng_flags;
    logic [17:0]       rd_data;
    logic              skip, irq, eng_start, eng_cancel, eng_write;
    logic [MA_W-1:0]   mem_addr;
    logic [17:0]       disk_addr;
    logic [WC_W-1:0]   word_count;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference state
    logic [17:0]     m_st, m_da, m_rd;
    logic [MA_W-1:0] m_ma;
    logic [WC_W-1:0] m_wc;
    logic            m_skip, m_start, m_cancel;

    always #2.5 clk = ~clk;

    disk_csr #(.MA_W(MA_W), .WC_W(WC_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pulse(cmd_pulse),
        .cmd_sub(cmd_sub), .host_data(host_data), .eng_flags(eng_flags),
        .rd_data(rd_data), .skip(skip), .irq(irq), .eng_start(eng_start),
        .eng_cancel(eng_cancel), .eng_write(eng_write), .mem_addr(mem_addr),
        .disk_addr(disk_addr), .word_count(word_count)
    );

    function automatic logic [17:0] fix_up(input logic [17:0] v);
        logic [17:0] r;
        r = v & 18'o377000;                      // R2: drop error and low bits
        if ((r & 18'o360000) != 0) r[17] = 1'b1;  // R4
        if (r[12]) r[10] = 1'b0;                 // R5
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic exp_irq;
        exp_irq = (m_st[17] | m_st[12]) & m_st[11];
        check(rd_data == m_rd, "R10 rd_data", 32'(rd_data), 32'(m_rd));
        check(skip == m_skip, "R8 skip", 32'(skip), 32'(m_skip));
        check(irq == exp_irq, "R6 irq", 32'(irq), 32'(exp_irq));
        check(eng_start == m_start && eng_cancel == m_cancel, "R12 start/cancel",
              32'({eng_start, eng_cancel}), 32'({m_start, m_cancel}));
        check(eng_write == m_st[9], "R12 write", 32'(eng_write), 32'(m_st[9]));
        check(mem_addr == m_ma && disk_addr == m_da && word_count == m_wc, "R11 addr regs",
              32'(disk_addr), 32'(m_da));
    endtask

    // Apply one command at a falling edge; model it and check at the next falling edge.
    task automatic step(input bit v, input logic [2:0] p, input logic [1:0] s,
                        input logic [17:0] d, input logic [4:0] f);
        logic [17:0] mid, rv, lw, nx;
        cmd_valid = v; cmd_pulse = p; cmd_sub = s; host_data = d; eng_flags = f;
        // R13: bit 0 first
        mid = m_st;
        m_skip = v && p[0] && s == 2'd1 && (m_st[17] || m_st[12]);        // R8
        if (v && p[0] && s == 2'd2)      mid = '0;                         // R9
        else if (v && p[0] && s == 2'd0) mid = m_st & 18'o007777;          // R7
        // then bit 1
        rv = '0;
        if (v && p[1] && s == 2'd0) rv = m_da;
        if (v && p[1] && s == 2'd1) rv = mid;
        lw = d | rv;
        nx = mid;
        m_start = 1'b0; m_cancel = 1'b0;
        if (v && p[2] && s == 2'd2) begin                                  // R3
            nx = (mid & 18'o007000) ^ (lw & 18'o777000);
            m_start = nx[10]; m_cancel = !nx[10];
        end
        nx = fix_up(nx | {1'b0, f, 12'b0});                                // R14
        if (v && p[1] && s == 2'd2) m_ma = lw[MA_W-1:0];
        if (v && p[2] && s == 2'd0) m_da = lw;
        if (v && p[2] && s == 2'd1) m_wc = lw[WC_W-1:0];
        m_rd = rv;
        m_st = nx;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    // Read the status through the host interface and compare with a fixed value.
    task automatic read_status(input logic [17:0] exp, input string tag);
        step(1'b1, 3'b010, 2'd1, 18'd0, 5'd0);
        check(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmd_valid = 0; cmd_pulse = 0; cmd_sub = 0; host_data = 0; eng_flags = 0;
        m_st = 0; m_da = 0; m_ma = 0; m_wc = 0; m_rd = 0; m_skip = 0; m_start = 0; m_cancel = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data == 0 && skip == 0 && eng_start == 0 && eng_cancel == 1 && irq == 0,
              "R1 reset outputs", 32'({rd_data, skip, eng_start, eng_cancel}), 32'h1);
        check(mem_addr == 0 && disk_addr == 0 && word_count == 0, "R1 reset regs",
              32'(disk_addr), 32'd0);
        rst_n = 1'b1;
        step(1'b0, 3'b000, 2'd3, 18'd0, 5'd0);
        // R3/R12: load IE|BSY|WR with low bits set
        step(1'b1, 3'b100, 2'd2, 18'o007777, 5'd0);
        check(eng_start == 1'b1 && eng_write == 1'b1, "R12 start on busy", 32'(eng_start), 32'd1);
        read_status(18'o007000, "R2 low bits zero after load");
        // R3: XOR retained bits, busy toggles off -> cancel
        step(1'b1, 3'b100, 2'd2, 18'o002000, 5'd0);
        check(eng_cancel == 1'b1, "R12 cancel on idle", 32'(eng_cancel), 32'd1);
        read_status(18'o005000, "R3 xor of retained bits");
        step(1'b1, 3'b100, 2'd2, 18'o002000, 5'd0);
        read_status(18'o007000, "R3 xor sets busy again");
        // R5/R6/R14: engine done
        step(1'b0, 3'b000, 2'd3, 18'd0, 5'b00001);
        check(irq == 1'b1, "R6 irq on done", 32'(irq), 32'd1);
        read_status(18'o015000, "R5 done clears busy");
        // R4/R14: illegal address flag
        step(1'b0, 3'b000, 2'd3, 18'd0, 5'b01000);
        read_status(18'o515000, "R4 error summary");
        // R8: skip
        step(1'b1, 3'b001, 2'd1, 18'd0, 5'd0);
        check(skip == 1'b1, "R8 skip taken", 32'(skip), 32'd1);
        // R7: clear flags
        step(1'b1, 3'b001, 2'd0, 18'd0, 5'd0);
        check(irq == 1'b0, "R7 irq gone after clear flags", 32'(irq), 32'd0);
        read_status(18'o005000, "R7 flags cleared");
        step(1'b1, 3'b001, 2'd1, 18'd0, 5'd0);
        check(skip == 1'b0, "R8 no skip", 32'(skip), 32'd0);
        // R13/R9: clear-all then status load in one command
        step(1'b1, 3'b101, 2'd2, 18'o004000, 5'd0);
        read_status(18'o004000, "R13 clear-all before load");
        step(1'b1, 3'b001, 2'd2, 18'd0, 5'd0);
        read_status(18'o000000, "R9 clear all");
        // R13/R10/R11: read DA and load DA together
        step(1'b1, 3'b100, 2'd0, 18'o000123, 5'd0);
        step(1'b1, 3'b110, 2'd0, 18'o000400, 5'd0);
        check(rd_data == 18'o000123, "R10 read address", 32'(rd_data), 32'o123);
        check(disk_addr == 18'o000523, "R13 load sees read value", 32'(disk_addr), 32'o523);
        // R11: MA and WC loads take low bits
        step(1'b1, 3'b010, 2'd2, 18'o777777, 5'd0);
        check(mem_addr == 15'h7fff, "R11 load MA", 32'(mem_addr), 32'h7fff);
        step(1'b1, 3'b100, 2'd1, 18'o654321, 5'd0);
        check(word_count == 16'(18'o654321), "R11 load WC", 32'(word_count), 32'(16'(18'o654321)));
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] fl;
            fl = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'd0;
            step($urandom_range(0, 5) != 0, 3'($urandom), 2'($urandom), 18'($urandom), fl);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule